// File: doc/BRIEF.md
# I2S microphone slave serializer

This block sends one mono audio source as a slave transmitter on an I2S data line. The host owns the bit clock and word select. A second transmitter, set to the opposite channel, shares the same data wire. A 24-bit two's-complement word is taken from a parallel input when the chosen half-frame begins. The word is shifted out MSB first with the standard one-bit delay. The output enable is high only while this source's own bits are on the wire.

The bit clock and word select arrive as ordinary inputs and are resynchronised into the system clock domain. A small edge detector turns them into rising and falling pulses. A slot tracker counts bit positions within each half-frame, and a shifter drives the line. The output enable is a separate port, so the tristate buffer and the pulldown on the shared wire stay outside the block.

Top module: `i2s_mic_tx`

## Requirements
- R1: Reset clears `sd_oe` and `sd_out` to 0. After reset the block drives nothing until it first sees a bit-clock rising edge at which word select differs from its value at the previous rising edge.
- R2: Word select is sampled on bit-clock rising edges: 0 marks the left half-frame and 1 the right. With `right_slot` = 0 the block transmits only in the left half, and with `right_slot` = 1 only in the right half.
- R3: The rising edge at which the word-select change is seen is slot 1 of the half-frame. Bit 23 (the MSB) is valid at the slot 2 rising edge and bit 0 at the slot 25 rising edge, one bit per bit-clock period, with all 24 bits unaltered.
- R4: `sd_out` and `sd_oe` change only in response to a bit-clock falling edge and hold steady while the bit clock is high.
- R5: `sd_oe` drops at the falling edge after the LSB. It stays low through slots 26 to the end of the half-frame and through the whole opposite half-frame.
- R6: The word is latched from `sample_in` at the rising edge that starts the selected half-frame. Later changes of `sample_in` do not alter the word being sent.
- R7: Half-frames of any length are handled. A half that ends early stops transmission at the first falling edge of the next half. A half longer than 32 slots never drives again, because the slot counter saturates instead of wrapping.
- R8: Two instances with opposite `right_slot` settings that share one line never assert their output enables at the same time.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock; the block samples the serial clock and word select with it |
| rst | input | 1 | Synchronous active-high reset |
| bclk | input | 1 | Serial bit clock from the host |
| wsel | input | 1 | Word select from the host (0 left, 1 right) |
| right_slot | input | 1 | Static channel choice: 0 left half-frame, 1 right half-frame |
| sample_in | input | 24 | Two's-complement sample offered to the serializer |
| sd_out | output | 1 | Serial data bit, meaningful while `sd_oe` is 1 |
| sd_oe | output | 1 | Output enable for the external tristate driver of the shared line |

## Verification
The assertions assume a bit clock whose high and low phases each last several system clocks longer than the synchroniser latency. They also assume that word select changes only with the falling bit-clock edge, and that `right_slot` is held constant outside reset. The stimulus meets these conditions: it holds each bit-clock phase for six system clocks and moves word select only together with a falling edge. It changes `sample_in` only at falling edges well away from the capturing rising edge. Two instances on one modelled line, with a pulldown, cover regular frames, a mid-word sample change, and irregular half-frame lengths of 3, 10, 12 and 70 slots.

// File: rtl/i2s_tx_pkg.sv
package i2s_tx_pkg;

    // Which half of the stereo frame a word select level denotes.
    typedef enum logic {
        SIDE_LEFT  = 1'b0,
        SIDE_RIGHT = 1'b1
    } slot_side_e;

    // One system-clock view of the serial clock and word select.
    typedef struct packed {
        logic rise;
        logic fall;
        logic ws;
    } bclk_evt_t;

endpackage

// File: rtl/i2s_edge_sync.sv
module i2s_edge_sync
    import i2s_tx_pkg::*;
#(
    parameter int STAGES = 2
) (
    input  logic      clk,
    input  logic      rst,
    input  logic      bclk_in,
    input  logic      ws_in,
    output bclk_evt_t evt
);

    localparam int TOP = STAGES - 1;

    logic [STAGES-1:0] bclk_sr;
    logic [STAGES-1:0] ws_sr;
    logic              bclk_last;

    // The chain runs freely, so it already follows the pins when reset ends.
    always_ff @(posedge clk) begin
        bclk_sr[0] <= bclk_in;
        ws_sr[0]   <= ws_in;
        for (int i = 1; i < STAGES; i++) begin
            bclk_sr[i] <= bclk_sr[i-1];
            ws_sr[i]   <= ws_sr[i-1];
        end
        bclk_last <= bclk_sr[TOP];
    end

    always_comb begin
        evt.rise = !rst && bclk_sr[TOP] && !bclk_last;
        evt.fall = !rst && !bclk_sr[TOP] && bclk_last;
        evt.ws   = ws_sr[TOP];
    end

endmodule

// File: rtl/i2s_slot_tracker.sv
module i2s_slot_tracker
    import i2s_tx_pkg::*;
#(
    parameter int CNT_W = 6
) (
    input  logic             clk,
    input  logic             rst,
    input  bclk_evt_t        evt,
    output logic [CNT_W-1:0] slot,
    output slot_side_e       half_side,
    output logic             started,
    output logic             half_start
);

    localparam logic [CNT_W-1:0] SLOT_MAX = '1;
    localparam logic [CNT_W-1:0] SLOT_ONE = CNT_W'(1);

    logic prev_ok;

    // A half-frame opens when word select differs from the previous sample.
    assign half_start = evt.rise && prev_ok && (evt.ws != logic'(half_side));

    always_ff @(posedge clk) begin
        if (rst) begin
            prev_ok   <= 1'b0;
            slot      <= '0;
            half_side <= SIDE_LEFT;
            started   <= 1'b0;
        end else if (evt.rise) begin
            prev_ok   <= 1'b1;
            half_side <= slot_side_e'(evt.ws);
            if (half_start) begin
                slot    <= SLOT_ONE;
                started <= 1'b1;
            end else if (slot != SLOT_MAX) begin
                slot <= slot + SLOT_ONE;
            end
        end
    end

endmodule

// File: rtl/i2s_word_shifter.sv
module i2s_word_shifter #(
    parameter int WORD_W = 24
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              capture,
    input  logic [WORD_W-1:0] word_in,
    input  logic              shift_tick,
    input  logic              in_window,
    output logic              sd,
    output logic              oe
);

    logic [WORD_W-1:0] shreg;

    always_ff @(posedge clk) begin
        if (rst) begin
            shreg <= '0;
            sd    <= 1'b0;
            oe    <= 1'b0;
        end else if (capture) begin
            shreg <= word_in;
        end else if (shift_tick) begin
            if (in_window) begin
                sd    <= shreg[WORD_W-1];
                shreg <= {shreg[WORD_W-2:0], 1'b0};
                oe    <= 1'b1;
            end else begin
                sd <= 1'b0;
                oe <= 1'b0;
            end
        end
    end

endmodule

// File: rtl/i2s_mic_tx.sv
module i2s_mic_tx
    import i2s_tx_pkg::*;
#(
    parameter int WORD_W      = 24,
    parameter int HALF_SLOTS  = 32,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              bclk,
    input  logic              wsel,
    input  logic              right_slot,
    input  logic [WORD_W-1:0] sample_in,
    output logic              sd_out,
    output logic              sd_oe
);

    localparam int               CNT_W     = $clog2(2 * HALF_SLOTS);
    localparam logic [CNT_W-1:0] LAST_SLOT = CNT_W'(WORD_W);

    bclk_evt_t        evt;
    logic [CNT_W-1:0] slot;
    slot_side_e       half_side;
    logic             started;
    logic             half_start;
    logic             own_half;
    logic             in_window;
    logic             capture;

    i2s_edge_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk     (clk),
        .rst     (rst),
        .bclk_in (bclk),
        .ws_in   (wsel),
        .evt     (evt)
    );

    i2s_slot_tracker #(.CNT_W(CNT_W)) u_track (
        .clk        (clk),
        .rst        (rst),
        .evt        (evt),
        .slot       (slot),
        .half_side  (half_side),
        .started    (started),
        .half_start (half_start)
    );

    // Slots 1..WORD_W of the own half precede the falls that put bits on the line.
    assign own_half  = started && (half_side == slot_side_e'(right_slot));
    assign in_window = own_half && (slot != '0) && (slot <= LAST_SLOT);
    assign capture   = half_start && (evt.ws == right_slot);

    i2s_word_shifter #(.WORD_W(WORD_W)) u_shift (
        .clk        (clk),
        .rst        (rst),
        .capture    (capture),
        .word_in    (sample_in),
        .shift_tick (evt.fall),
        .in_window  (in_window),
        .sd         (sd_out),
        .oe         (sd_oe)
    );

endmodule

// File: rtl/i2s_mic_tx_chk.sv
module i2s_mic_tx_chk #(
    parameter int WORD_W = 24,
    parameter int CNT_W  = 6
) (
    input logic             clk,
    input logic             rst,
    input logic             right_slot,
    input logic             sd_oe,
    input logic             sd_out,
    input logic             fall_pulse,
    input logic [CNT_W-1:0] slot,
    input logic             half_side,
    input logic             started
);

    int unsigned run;

    // Falling edges seen while the enable has been continuously high.
    always_ff @(posedge clk) begin
        if (rst || !sd_oe)
            run <= 0;
        else if (fall_pulse)
            run <= run + 1;
    end

    assert_idle_in_reset_R1: assert property (@(posedge clk)
        rst |=> !sd_oe);

    assert_quiet_before_start_R1: assert property (@(posedge clk) disable iff (rst)
        !started |-> !sd_oe);

    assert_static_select_R2: assert property (@(posedge clk) disable iff (rst)
        $stable(right_slot));

    assert_msb_entry_R3: assert property (@(posedge clk) disable iff (rst)
        $rose(sd_oe) |-> (slot == CNT_W'(1)) && (half_side == right_slot));

    assert_fall_only_R4: assert property (@(posedge clk) disable iff (rst)
        !fall_pulse |=> ($stable(sd_oe) && $stable(sd_out)));

    assert_burst_len_R5: assert property (@(posedge clk) disable iff (rst)
        sd_oe |-> (run < unsigned'(WORD_W)));

endmodule

bind i2s_mic_tx i2s_mic_tx_chk #(.WORD_W(WORD_W), .CNT_W(CNT_W)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .right_slot (right_slot),
    .sd_oe      (sd_oe),
    .sd_out     (sd_out),
    .fall_pulse (evt.fall),
    .slot       (slot),
    .half_side  (half_side),
    .started    (started)
);

// File: tb/i2s_mic_tx_bench.sv
`timescale 1ns/1ps
module i2s_mic_tx_bench;

    localparam int W = 24;
    localparam int H = 6;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic bclk = 1'b1;
    logic wsel = 1'b0;
    logic [W-1:0] samp_l = '0;
    logic [W-1:0] samp_r = '0;
    logic sd_l, oe_l, sd_r, oe_r, sd_line;

    always #2.5 clk = ~clk;

    // Shared wire with a weak pulldown.
    assign sd_line = oe_l ? sd_l : (oe_r ? sd_r : 1'b0);

    i2s_mic_tx u_i2s_mic_tx (
        .clk(clk), .rst(rst), .bclk(bclk), .wsel(wsel), .right_slot(1'b0),
        .sample_in(samp_l), .sd_out(sd_l), .sd_oe(oe_l)
    );

    i2s_mic_tx u_i2s_mic_tx_r (
        .clk(clk), .rst(rst), .bclk(bclk), .wsel(wsel), .right_slot(1'b1),
        .sample_in(samp_r), .sd_out(sd_r), .sd_oe(oe_r)
    );

    typedef struct {
        logic  oe_l;
        logic  oe_r;
        logic  bitv;
        string tag;
    } exp_t;

    exp_t q[$];
    int checks = 0;
    int errors = 0;

    // Requirement model state.
    logic         m_prev_ws = 1'b0;
    bit           m_prev_ok = 1'b0;
    bit           m_seen    = 1'b0;
    int           m_slot    = 0;
    logic [W-1:0] m_word [2];
    logic         m_oe   [2];
    logic         m_bit  [2];

    task automatic check(string tag, string what, logic [W-1:0] act, logic [W-1:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual=%0h expected=%0h", tag, what, act, exp);
        end
    endtask

    task automatic summary_and_end();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    endtask

    // One bit-clock period: falling edge (word select moves), then rising edge.
    task automatic bit_cycle(logic ws_v, string tag);
        exp_t e;
        for (int i = 0; i < 2; i++) begin
            if (m_seen && (m_prev_ws == logic'(i)) && m_slot >= 1 && m_slot <= W) begin
                m_oe[i]  = 1'b1;
                m_bit[i] = m_word[i][W - m_slot];
            end else begin
                m_oe[i]  = 1'b0;
                m_bit[i] = 1'b0;
            end
        end
        e.oe_l = m_oe[0];
        e.oe_r = m_oe[1];
        e.bitv = m_oe[0] ? m_bit[0] : (m_oe[1] ? m_bit[1] : 1'b0);
        e.tag  = tag;
        q.push_back(e);
        bclk = 1'b0;
        wsel = ws_v;
        repeat (H) @(negedge clk);
        if (m_prev_ok && ws_v != m_prev_ws) begin
            m_slot = 1;
            m_seen = 1'b1;
            m_word[int'(ws_v)] = ws_v ? samp_r : samp_l;
        end else begin
            m_slot++;
        end
        m_prev_ok = 1'b1;
        m_prev_ws = ws_v;
        bclk = 1'b1;
        repeat (H) @(negedge clk);
    endtask

    task automatic half(logic ws_v, int len, string tag, int chg_at, logic [W-1:0] chg_val);
        for (int k = 0; k < len; k++) begin
            if (k == chg_at) begin
                if (ws_v) samp_r = chg_val;
                else      samp_l = chg_val;
            end
            bit_cycle(ws_v, tag);
        end
    endtask

    task automatic frame(logic [W-1:0] l, logic [W-1:0] r, string tag);
        samp_l = l;
        samp_r = r;
        half(1'b0, 32, tag, -1, '0);
        half(1'b1, 32, tag, -1, '0);
    endtask

    // Monitor: pops one expectation per rising bit-clock edge.
    initial begin
        exp_t e;
        logic s_oe_l, s_oe_r, s_sd_l, s_sd_r;
        forever begin
            @(posedge bclk);
            if (q.size() == 0) begin
                check("R3", "unexpected rising edge", 1, 0);
            end else begin
                e = q.pop_front();
                check(e.tag, "left enable", oe_l, e.oe_l);
                check(e.tag, "right enable", oe_r, e.oe_r);
                check(e.tag, "line bit", sd_line, e.bitv);
                check("R8", "both enables high", oe_l & oe_r, 0);
            end
            s_oe_l = oe_l; s_oe_r = oe_r; s_sd_l = sd_l; s_sd_r = sd_r;
            @(negedge bclk);
            check("R4", "left enable moved in high phase", oe_l, s_oe_l);
            check("R4", "right enable moved in high phase", oe_r, s_oe_r);
            check("R4", "left data moved in high phase", sd_l, s_sd_l);
            check("R4", "right data moved in high phase", sd_r, s_sd_r);
        end
    end

    // Watchdog.
    initial begin
        repeat (200000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL R3 watchdog: actual=timeout expected=completion");
        summary_and_end();
    end

    initial begin
        repeat (8) @(negedge clk);
        rst = 1'b0;
        repeat (4) @(negedge clk);
        check("R1", "left enable after reset", oe_l, 0);
        check("R1", "right enable after reset", oe_r, 0);
        check("R1", "line after reset", sd_line, 0);

        // R1: no word-select transition yet, so nothing may drive.
        half(1'b0, 40, "R1", -1, '0);
        // R2: first transition opens a right half.
        samp_r = 24'h800000;
        half(1'b1, 32, "R2", -1, '0);
        frame(24'h7FFFFF, 24'h000001, "R3");
        frame(24'hA5C3E1, 24'h5A3C1E, "R5");
        frame(24'h800000, 24'hFFFFFF, "R2");
        // R6: the source changes while the word is on the line.
        samp_l = 24'h123456;
        samp_r = 24'h0F0F0F;
        half(1'b0, 32, "R6", 5, 24'hFEDCBA);
        half(1'b1, 32, "R6", 9, 24'hABCDEF);
        // R7: over-long halves, then short ones.
        samp_l = 24'hC0FFEE;
        samp_r = 24'h3C3C3C;
        half(1'b0, 70, "R7", -1, '0);
        half(1'b1, 70, "R7", -1, '0);
        samp_l = 24'hF00F55;
        samp_r = 24'h9ABCDE;
        half(1'b0, 10, "R7", -1, '0);
        half(1'b1, 12, "R7", -1, '0);
        samp_l = 24'h5A5A5A;
        half(1'b0, 3, "R7", -1, '0);
        half(1'b1, 32, "R7", -1, '0);
        frame(24'h00FF00, 24'hFF00FF, "R3");
        half(1'b0, 4, "R5", -1, '0);

        repeat (20) @(negedge clk);
        check("R3", "pending expectations", q.size(), 0);
        summary_and_end();
    end

endmodule